// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clocks for an audio serial port. These are a bit clock and two frame clocks, one for transmit and one for receive. In master mode it builds them from the master clock. A programmable divider sets the bit clock. Two more dividers, one per direction, count bit clocks to set each frame length. In slave mode it takes the bit and frame clocks from the pins instead. It brings them into the master-clock domain through a synchronizer and forwards them.

Each of the three clock outputs has its own polarity invert. A sharing mode can drive both frame outputs from the transmit frame clock or from the receive frame clock. The serializers that sit beside the block receive a one-cycle enable at each active bit-clock edge, so they can run on the master clock alone. Every divider stays at its start point while neither direction is started, or while the clear input is high. A restart therefore always begins a fresh frame.

Top module: `aclk_gen`

## Requirements
- R1: After reset, with both start inputs low, bclk_o equals bclk_inv_i, tx_fs_o equals tx_fs_inv_i, rx_fs_o equals rx_fs_inv_i, and bclk_ce_o is 0.
- R2: The block runs only while (tx_start_i or rx_start_i) is high and clear_i is low. Either start input alone is enough. In master mode, while it is not running, every divider sits at zero, the uninverted bit and frame clocks are low, and bclk_ce_o stays 0.
- R3: In master mode the bit-clock ratio N is bdiv_m1_i+1, with a field value of 0 treated as N=2. The uninverted bit clock repeats every N master cycles. It is high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R4: bclk_ce_o is high for exactly one master cycle per bit-clock period. It is high in the first cycle in which the uninverted bit clock reads 1, so it marks the rising edge of bclk_o when bclk_inv_i=0 and the falling edge when bclk_inv_i=1.
- R5: In master mode, frame ratio F is the frame field plus 1, with 0 treated as F=2. The uninverted frame clock is high for floor(F/2) bit periods and low for ceil(F/2) bit periods. It changes only in a cycle in which bclk_ce_o is high.
- R6: With share_mode_i=0, the transmit frame clock uses tx_fdiv_m1_i and the receive frame clock uses rx_fdiv_m1_i, and each runs at its own ratio.
- R7: share_mode_i=1 drives both frame outputs from the transmit frame source. share_mode_i=2 drives both from the receive frame source. share_mode_i=3 behaves as 0. Each output still applies its own invert bit.
- R8: Each invert bit XORs only its own output, in both master and slave mode.
- R9: With slave_i=1, bclk_o, tx_fs_o and rx_fs_o follow ext_bclk_i, ext_tx_fs_i and ext_rx_fs_i two master-clock edges after a change, with sharing and inversion applied. bclk_ce_o pulses once per synchronized rising edge of ext_bclk_i, but only while the block runs.
- R10: After the run condition becomes true, the first bclk_ce_o appears after the ceil(N/2)-th master edge. Each frame clock first rises at the ceil(F/2)-th bit-clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 0: generate clocks, 1: take clocks from pins |
| bdiv_m1_i | input | 8 | Bit-clock ratio minus one |
| tx_fdiv_m1_i | input | 8 | Transmit bit clocks per frame minus one |
| rx_fdiv_m1_i | input | 8 | Receive bit clocks per frame minus one |
| bclk_inv_i | input | 1 | Invert bit clock output |
| tx_fs_inv_i | input | 1 | Invert transmit frame clock output |
| rx_fs_inv_i | input | 1 | Invert receive frame clock output |
| share_mode_i | input | 2 | 0 independent, 1 both from tx, 2 both from rx |
| tx_start_i | input | 1 | Transmit started |
| rx_start_i | input | 1 | Receive started |
| clear_i | input | 1 | Hold all dividers at their start point |
| ext_bclk_i | input | 1 | External bit clock (slave) |
| ext_tx_fs_i | input | 1 | External transmit frame clock (slave) |
| ext_rx_fs_i | input | 1 | External receive frame clock (slave) |
| bclk_o | output | 1 | Bit clock |
| tx_fs_o | output | 1 | Transmit frame clock |
| rx_fs_o | output | 1 | Receive frame clock |
| bclk_ce_o | output | 1 | One-cycle enable at the active bit-clock edge |

## Verification
The bench measures high and low run lengths for odd ratios, where an evenly split divider would give equal phases. It also measures the zero field, where a divider taken literally would stop or run at the master rate. Sharing modes 1 and 2 are run with deliberately different frame ratios, so a swapped or ignored mux shows up as the wrong frame length. Mode 3 is checked against independent behaviour. The restart test counts the exact edge of the first enable and of the first frame rise, which catches counters that do not return to zero on clear. The slave tests count the synchronizer delay edge by edge, and they confirm that a stopped block emits no enables even while the external clock toggles.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    SHARE_NONE = 2'd0,
    SHARE_TX   = 2'd1,
    SHARE_RX   = 2'd2,
    SHARE_RSV  = 2'd3
  } share_e;

  localparam int unsigned DIV_W   = 8;
  localparam int unsigned SYNC_ST = 2;
  localparam int unsigned N_FRAME = 2;  // index 0 tx, 1 rx
endpackage

// File: rtl/aclk_div.sv
// Phase divider: counts adv_i pulses, level low for ceil(R/2), high for floor(R/2).
module aclk_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         adv_i,
  input  logic [W-1:0] div_m1_i,
  output logic         lvl_o,
  output logic         rise_nxt_o,
  output logic         rise_o
);
  localparam logic [W:0] ONE = (W+1)'(1);
  localparam logic [W:0] TWO = (W+1)'(2);

  logic [W:0] ratio, lo_len, cnt_q, cnt_d;

  always_comb begin
    ratio  = (div_m1_i == '0) ? TWO : ({1'b0, div_m1_i} + ONE);
    lo_len = (ratio + ONE) >> 1;
    if (!run_i)             cnt_d = '0;
    else if (!adv_i)        cnt_d = cnt_q;
    else if (cnt_q >= ratio - ONE) cnt_d = '0;
    else                    cnt_d = cnt_q + ONE;
  end

  assign rise_nxt_o = run_i && adv_i && (cnt_d == lo_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_o  <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_o  <= run_i && (cnt_d >= lo_len);
      rise_o <= rise_nxt_o;
    end
  end
endmodule

// File: rtl/aclk_sync.sv
// Multi-stage synchronizer for external clocks, rising-edge detect on bit 0.
module aclk_sync #(
  parameter int unsigned N_SIG  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SIG-1:0] async_i,
  output logic [N_SIG-1:0] sync_o,
  output logic             rise0_o
);
  logic last0_q;

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last0_q <= 1'b0;
    else         last0_q <= sync_o[0];
  end

  assign rise0_o = sync_o[0] & ~last0_q;
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slave_i,
  input  logic [W-1:0] bdiv_m1_i,
  input  logic [W-1:0] tx_fdiv_m1_i,
  input  logic [W-1:0] rx_fdiv_m1_i,
  input  logic         bclk_inv_i,
  input  logic         tx_fs_inv_i,
  input  logic         rx_fs_inv_i,
  input  logic [1:0]   share_mode_i,
  input  logic         tx_start_i,
  input  logic         rx_start_i,
  input  logic         clear_i,
  input  logic         ext_bclk_i,
  input  logic         ext_tx_fs_i,
  input  logic         ext_rx_fs_i,
  output logic         bclk_o,
  output logic         tx_fs_o,
  output logic         rx_fs_o,
  output logic         bclk_ce_o
);
  logic run;
  logic m_bclk, m_tick_nxt, m_ce;
  logic [N_FRAME-1:0] m_fs;
  logic [W-1:0] fdiv [N_FRAME];
  logic [2:0] s_sig;
  logic s_rise;
  logic src_bclk, src_tx, src_rx, sel_tx, sel_rx;
  share_e share;

  assign run     = (tx_start_i | rx_start_i) & ~clear_i;
  assign fdiv[0] = tx_fdiv_m1_i;
  assign fdiv[1] = rx_fdiv_m1_i;
  assign share   = share_e'(share_mode_i);

  aclk_div #(.W(W)) u_bit_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .adv_i     (1'b1),
    .div_m1_i  (bdiv_m1_i),
    .lvl_o     (m_bclk),
    .rise_nxt_o(m_tick_nxt),
    .rise_o    (m_ce)
  );

  for (genvar f = 0; f < N_FRAME; f++) begin : g_frame
    logic unused_nxt, unused_rise;
    aclk_div #(.W(W)) u_frame_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .adv_i     (m_tick_nxt),
      .div_m1_i  (fdiv[f]),
      .lvl_o     (m_fs[f]),
      .rise_nxt_o(unused_nxt),
      .rise_o    (unused_rise)
    );
  end

  aclk_sync #(.N_SIG(3), .STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ext_rx_fs_i, ext_tx_fs_i, ext_bclk_i}),
    .sync_o (s_sig),
    .rise0_o(s_rise)
  );

  always_comb begin
    src_bclk = slave_i ? s_sig[0] : m_bclk;
    src_tx   = slave_i ? s_sig[1] : m_fs[0];
    src_rx   = slave_i ? s_sig[2] : m_fs[1];
    unique case (share)
      SHARE_TX: begin sel_tx = src_tx; sel_rx = src_tx; end
      SHARE_RX: begin sel_tx = src_rx; sel_rx = src_rx; end
      default:  begin sel_tx = src_tx; sel_rx = src_rx; end
    endcase
  end

  assign bclk_o    = src_bclk ^ bclk_inv_i;
  assign tx_fs_o   = sel_tx ^ tx_fs_inv_i;
  assign rx_fs_o   = sel_rx ^ rx_fs_inv_i;
  assign bclk_ce_o = slave_i ? (s_rise & run) : m_ce;
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slave_i,
  input logic       bclk_inv_i,
  input logic       tx_fs_inv_i,
  input logic       rx_fs_inv_i,
  input logic [1:0] share_mode_i,
  input logic       tx_start_i,
  input logic       rx_start_i,
  input logic       clear_i,
  input logic       bclk_o,
  input logic       tx_fs_o,
  input logic       rx_fs_o,
  input logic       bclk_ce_o
);
  logic running;
  assign running = (tx_start_i | rx_start_i) & ~clear_i;

  AST_CE_AT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_ce_o |-> (bclk_o ^ bclk_inv_i)); // R4
  AST_CE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_ce_o |=> !bclk_ce_o); // R4
  AST_IDLE_NO_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !running) |=> (!bclk_ce_o || slave_i)); // R2
  AST_IDLE_BCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !running && $past(!slave_i && !running)) |-> (bclk_o == bclk_inv_i)); // R2
  AST_SHARE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (share_mode_i == 2'd1) |-> ((rx_fs_o ^ rx_fs_inv_i) == (tx_fs_o ^ tx_fs_inv_i))); // R7
  AST_SHARE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (share_mode_i == 2'd2) |-> ((rx_fs_o ^ rx_fs_inv_i) == (tx_fs_o ^ tx_fs_inv_i))); // R7
  AST_FS_ON_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && $past(!slave_i) && $past(running) && $stable(tx_fs_inv_i)
     && $stable(share_mode_i) && (tx_fs_o != $past(tx_fs_o))) |-> bclk_ce_o); // R5
endmodule

bind aclk_gen aclk_gen_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slave_i     (slave_i),
  .bclk_inv_i  (bclk_inv_i),
  .tx_fs_inv_i (tx_fs_inv_i),
  .rx_fs_inv_i (rx_fs_inv_i),
  .share_mode_i(share_mode_i),
  .tx_start_i  (tx_start_i),
  .rx_start_i  (rx_start_i),
  .clear_i     (clear_i),
  .bclk_o      (bclk_o),
  .tx_fs_o     (tx_fs_o),
  .rx_fs_o     (rx_fs_o),
  .bclk_ce_o   (bclk_ce_o)
);

// File: tb/aclk_gen_tb_top.sv
module aclk_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slave = 0, binv = 0, tinv = 0, rinv = 0, txs = 0, rxs = 0, clr = 0;
  logic ebclk = 0, etfs = 0, erfs = 0;
  logic [7:0] bdiv = 0, tdiv = 0, rdiv = 0;
  logic [1:0] share = 0;
  logic bclk, tfs, rfs, ce;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  aclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .bdiv_m1_i(bdiv),
    .tx_fdiv_m1_i(tdiv), .rx_fdiv_m1_i(rdiv), .bclk_inv_i(binv),
    .tx_fs_inv_i(tinv), .rx_fs_inv_i(rinv), .share_mode_i(share),
    .tx_start_i(txs), .rx_start_i(rxs), .clear_i(clr),
    .ext_bclk_i(ebclk), .ext_tx_fs_i(etfs), .ext_rx_fs_i(erfs),
    .bclk_o(bclk), .tx_fs_o(tfs), .rx_fs_o(rfs), .bclk_ce_o(ce)
  );

  // b, ft, fr, share, ib, it, ir, exp bclk hi/lo, tx hi/lo, rx hi/lo
  localparam int VEC [7][13] = '{
    '{3, 7, 3, 0, 0, 0, 0, 2, 2, 4, 4, 2, 2},
    '{4, 4, 2, 0, 0, 0, 0, 2, 3, 2, 3, 1, 2},
    '{0, 0, 5, 0, 0, 0, 0, 1, 1, 1, 1, 3, 3},
    '{2, 5, 1, 1, 0, 0, 0, 1, 2, 3, 3, 3, 3},
    '{1, 1, 6, 2, 0, 0, 0, 1, 1, 3, 4, 3, 4},
    '{4, 2, 3, 3, 1, 1, 0, 3, 2, 2, 1, 2, 2},
    '{6, 9, 4, 1, 0, 0, 1, 3, 4, 5, 5, 5, 5}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      total++; bad++;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig_of(int sel);
    case (sel)
      0: return bclk;
      1: return tfs;
      default: return rfs;
    endcase
  endfunction

  task automatic meas(int sel, bit by_ce, output int hi, output int lo);
    int lim;
    hi = 0; lo = 0; lim = 0;
    while (sig_of(sel) != 1'b0 && lim < 4000) begin tick(); lim++; end
    while (sig_of(sel) != 1'b1 && lim < 4000) begin tick(); lim++; end
    while (sig_of(sel) == 1'b1 && lim < 4000) begin hi += by_ce ? int'(ce) : 1; tick(); lim++; end
    while (sig_of(sel) == 1'b0 && lim < 4000) begin lo += by_ce ? int'(ce) : 1; tick(); lim++; end
  endtask

  initial begin
    int h, l, first_ce, ce_cnt;
    #1;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 bclk", bclk, 0); chk("R1 tx_fs", tfs, 0);
    chk("R1 rx_fs", rfs, 0); chk("R1 ce", ce, 0);

    // R2 idle: no start
    bdiv = 3; ce_cnt = 0;
    for (int i = 0; i < 20; i++) begin tick(); ce_cnt += int'(ce) + int'(bclk); end
    chk("R2 idle no activity", ce_cnt, 0);
    // R2 clear overrides start
    txs = 1; clr = 1; ce_cnt = 0;
    for (int i = 0; i < 20; i++) begin tick(); ce_cnt += int'(ce) + int'(bclk); end
    chk("R2 clear holds", ce_cnt, 0);

    // R8 idle polarity: only tx inverted
    tinv = 1; #1;
    chk("R8 tx inv", tfs, 1); chk("R8 rx untouched", rfs, 0); chk("R8 bclk untouched", bclk, 0);
    tinv = 0;

    // main table: R3 R5 R6 R7 R8
    for (int v = 0; v < 7; v++) begin
      clr = 1; txs = 1; rxs = 1;
      bdiv = 8'(VEC[v][0]); tdiv = 8'(VEC[v][1]); rdiv = 8'(VEC[v][2]);
      share = 2'(VEC[v][3]); binv = VEC[v][4][0]; tinv = VEC[v][5][0]; rinv = VEC[v][6][0];
      tick(); tick();
      clr = 0;
      meas(0, 1'b0, h, l);
      chk($sformatf("R3 v%0d bclk hi", v), h, VEC[v][7]);
      chk($sformatf("R3 v%0d bclk lo", v), l, VEC[v][8]);
      meas(1, 1'b1, h, l);
      chk($sformatf("R5 v%0d tx hi", v), h, VEC[v][9]);
      chk($sformatf("R5 v%0d tx lo", v), l, VEC[v][10]);
      meas(2, 1'b1, h, l);
      chk($sformatf("R6 R7 v%0d rx hi", v), h, VEC[v][11]);
      chk($sformatf("R6 R7 v%0d rx lo", v), l, VEC[v][12]);
    end

    // R4: one enable per bit period, inside high phase (no inversion)
    clr = 1; binv = 0; tinv = 0; rinv = 0; share = 0; bdiv = 4;
    tick(); clr = 0;
    meas(0, 1'b1, h, l);
    chk("R4 ce in high phase", h, 1); chk("R4 ce in low phase", l, 0);

    // R10 restart timing: N=6 (lo 3), F=4 (lo 2)
    clr = 1; bdiv = 5; tdiv = 3; rdiv = 3; txs = 0; rxs = 1;
    tick(); tick();
    clr = 0; first_ce = 0; ce_cnt = 0;
    for (int k = 1; k <= 9; k++) begin
      tick();
      if (ce) begin ce_cnt++; if (first_ce == 0) first_ce = k; end
      if (k == 8) chk("R10 tx_fs low before 2nd ce", tfs, 0);
      if (k == 9) begin
        chk("R10 2nd ce edge", ce, 1);
        chk("R10 tx_fs rises at 2nd ce", tfs, 1);
      end
    end
    chk("R10 first ce edge", first_ce, 3);
    chk("R10 ce count", ce_cnt, 2);

    // R9 slave pass-through, share 2
    slave = 1; share = 2; clr = 0; txs = 1; rxs = 0;
    tick(); tick(); tick();
    ebclk = 1;
    tick(); chk("R9 bclk after 1 edge", bclk, 0);
    tick(); chk("R9 bclk after 2 edges", bclk, 1); chk("R9 ce on sync rise", ce, 1);
    tick(); chk("R9 ce single", ce, 0);
    etfs = 0; erfs = 1;
    tick(); tick();
    chk("R9 R7 tx from rx source", tfs, 1); chk("R9 rx", rfs, 1);
    binv = 1; #1;
    chk("R8 slave bclk inv", bclk, 0);
    binv = 0;
    // stopped: external edges give no enable
    txs = 0; ebclk = 0; tick(); tick(); tick();
    ebclk = 1; ce_cnt = 0;
    for (int i = 0; i < 5; i++) begin tick(); ce_cnt += int'(ce); end
    chk("R9 no ce when stopped", ce_cnt, 0);
    chk("R9 bclk still follows", bclk, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule